// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates one 32-bit virtual address at a time with a two-level, radix-1024 page table of 4-byte entries. A request carries the address, the access kind (instruction fetch, data load or data store), the current privilege, and the status bits that bear on translation. The walker reads page table entries over a single-request memory port. It applies a fixed order of legality and permission checks to each entry. When it finds a legal leaf it sets the accessed bit, and also the dirty bit on a store, with a conditional write. It returns a physical address with read/write/execute permissions, or a fault.

The write-back is a compare-and-write. The memory side swaps the entry only if it still holds the value the walker read. If another agent changed the entry in the meantime, memory reports a mismatch and the walker starts the whole walk again from the root. When the effective privilege is machine mode, or translation is switched off, the walker maps the address one-to-one with full permissions and touches no memory.

Top module: `pgwalk_top`

## Requirements
- R1: With translation off, or with an effective privilege of machine (privilege code 3), the result is the zero-extended virtual address with read, write and execute all granted, and no memory request is issued.
- R2: For a load or store (access code 1 = load, 2 = store, 0 = fetch, 3 treated as load) issued in machine mode with the modify-privilege bit set, the saved previous-privilege field is the effective privilege. Fetches ignore that bit.
- R3: The first entry read is at root page number × 4096 + VA[31:22] × 4. A pointer entry with page number P leads to the second read at P × 4096 + VA[21:12] × 4. Entry bits are V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7, and the page number sits in bits 31:10.
- R4: An entry with V clear faults. A pointer entry (R, W and X all clear) found at the second level faults.
- R5: A valid entry with W set and R clear faults, whether or not X is set.
- R6: A U=1 page faults in supervisor mode when the supervisor-user-access bit is clear or the access is a fetch. In user mode a U=1 page is usable.
- R7: A U=0 page faults whenever the effective privilege is not supervisor.
- R8: A first-level leaf whose page number has any of bits 9:0 set faults as misaligned. For an aligned first-level leaf, PA[21:12] are taken from VA[21:12].
- R9: A load needs R, or X with the make-executable-readable bit set. A store needs W. A fetch needs X. Otherwise the access faults.
- R10: A legal leaf gets A set, and D also set on a store. If that changes the entry, a write goes out carrying the new value and the value read as the compare value. An entry that is already up to date is not written.
- R11: A write answered with a mismatch makes the walker restart from the root entry and check the re-read entries afresh.
- R12: Granted read is R, or X with make-executable-readable. Granted execute is X. Granted write is W only when the access is a store or D was already set. A fault grants nothing and reports a zero address.
- R13: The request port is ready only while idle. A memory request holds its address and kind until accepted. The result is flagged valid for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_mprv | input | 1 | Modify-privilege bit for data accesses |
| req_mpp | input | 2 | Saved previous privilege |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Executable pages are also readable |
| req_xlate_on | input | 1 | Paged translation enabled |
| req_root_ppn | input | 22 | Root table page number |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = compare-and-write, 0 = read |
| mem_req_addr | output | 34 | Entry physical address |
| mem_req_wdata | output | 32 | Updated entry for write |
| mem_req_cmp | output | 32 | Expected current entry for write |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_rdata | input | 32 | Entry read data |
| mem_rsp_mismatch | input | 1 | Write skipped: entry differed from compare value |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_fault | output | 1 | Translation faulted |
| rsp_paddr | output | 34 | Physical address |
| rsp_r | output | 1 | Read permitted |
| rsp_w | output | 1 | Write permitted |
| rsp_x | output | 1 | Execute permitted |

## Verification
The bench builds the walker with its default parameters: 32-bit virtual and 34-bit physical addresses, two levels of 10-bit indices, and 12-bit pages. These make both the 4 KiB leaf and the 4 MiB first-level superpage reachable, together with the misaligned superpage case. Its memory model accepts a request only every other cycle, so request holding under back-pressure is exercised. It can also alter an entry just before a compare-and-write, which drives the mismatch-and-rewalk path.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    // entry flag positions (decoded by the memory-side page table format)
    localparam int B_V = 0;
    localparam int B_R = 1;
    localparam int B_W = 2;
    localparam int B_X = 3;
    localparam int B_U = 4;
    localparam int B_G = 5;
    localparam int B_A = 6;
    localparam int B_D = 7;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        VD_FAULT = 2'd0,
        VD_NEXT  = 2'd1,
        VD_LEAF  = 2'd2
    } verdict_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_WAIT = 3'd2,
        ST_WB_REQ  = 3'd3,
        ST_WB_WAIT = 3'd4,
        ST_DONE    = 3'd5
    } wstate_e;

endpackage

// File: rtl/pgwalk_mode.sv
module pgwalk_mode
    import pgwalk_pkg::*;
(
    input  logic [1:0] priv,
    input  logic       mprv,
    input  logic [1:0] mpp,
    input  logic [1:0] acc_raw,
    input  logic       xlate_on,
    output acc_e       acc,
    output logic [1:0] eff_mode,
    output logic       bypass
);
    always_comb begin
        unique case (acc_raw)
            2'd0:    acc = ACC_FETCH;
            2'd2:    acc = ACC_STORE;
            default: acc = ACC_LOAD;
        endcase
        eff_mode = priv;
        if (priv == PRIV_M && acc != ACC_FETCH && mprv) begin
            eff_mode = mpp;
        end
        bypass = (eff_mode == PRIV_M) || !xlate_on;
    end
endmodule

// File: rtl/pgwalk_pte_chk.sv
module pgwalk_pte_chk
    import pgwalk_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int PPN_W = 22,
    parameter int VPN_W = 20,
    parameter int IDX_W = 10,
    parameter int LVL_W = 1
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [LVL_W-1:0] lvl,
    input  logic [1:0]       mode,
    input  acc_e             acc,
    input  logic             sum,
    input  logic             mxr,
    input  logic [VPN_W-1:0] vpn,
    output verdict_e         verdict,
    output logic [PTE_W-1:0] pte_upd,
    output logic [PPN_W-1:0] leaf_ppn,
    output logic [2:0]       perm
);
    localparam int PPN_LSB = PTE_W - PPN_W;

    logic [PPN_W-1:0] ppn;
    logic [PPN_W-1:0] vpn_x;
    logic             misal;
    logic             f_v, f_r, f_w, f_x, f_u;
    int               span;

    assign ppn   = pte[PTE_W-1:PPN_LSB];
    assign vpn_x = PPN_W'(vpn);
    assign f_v   = pte[B_V];
    assign f_r   = pte[B_R];
    assign f_w   = pte[B_W];
    assign f_x   = pte[B_X];
    assign f_u   = pte[B_U];

    // superpage: low page-number bits must be zero and come from the VA
    always_comb begin
        span  = int'(lvl) * IDX_W;
        misal = 1'b0;
        for (int i = 0; i < PPN_W; i++) begin
            if (i < span) begin
                misal       = misal | ppn[i];
                leaf_ppn[i] = vpn_x[i];
            end else begin
                leaf_ppn[i] = ppn[i];
            end
        end
    end

    // ordered legality chain
    always_comb begin
        verdict = VD_LEAF;
        if (!f_v) begin
            verdict = VD_FAULT;
        end else if (!f_r && !f_w && !f_x) begin
            verdict = VD_NEXT;
        end else if (f_w && !f_r) begin
            verdict = VD_FAULT;
        end else if (f_u && mode != PRIV_U && (!sum || acc == ACC_FETCH)) begin
            verdict = VD_FAULT;
        end else if (!f_u && mode != PRIV_S) begin
            verdict = VD_FAULT;
        end else if (misal) begin
            verdict = VD_FAULT;
        end else if (acc == ACC_LOAD && !(f_r || (f_x && mxr))) begin
            verdict = VD_FAULT;
        end else if (acc == ACC_STORE && !f_w) begin
            verdict = VD_FAULT;
        end else if (acc == ACC_FETCH && !f_x) begin
            verdict = VD_FAULT;
        end
    end

    always_comb begin
        pte_upd = pte;
        pte_upd[B_A] = 1'b1;
        if (acc == ACC_STORE) begin
            pte_upd[B_D] = 1'b1;
        end
        // write withheld on a clean page so the first store comes back here
        perm = {f_r | (f_x & mxr), f_w & pte_upd[B_D], f_x};
    end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PA_W   = 34,
    parameter int PTE_W  = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [1:0]            req_acc,
    input  logic [1:0]            req_priv,
    input  logic                  req_mprv,
    input  logic [1:0]            req_mpp,
    input  logic                  req_sum,
    input  logic                  req_mxr,
    input  logic                  req_xlate_on,
    input  logic [PA_W-OFF_W-1:0] req_root_ppn,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_write,
    output logic [PA_W-1:0]       mem_req_addr,
    output logic [PTE_W-1:0]      mem_req_wdata,
    output logic [PTE_W-1:0]      mem_req_cmp,
    input  logic                  mem_rsp_valid,
    input  logic [PTE_W-1:0]      mem_rsp_rdata,
    input  logic                  mem_rsp_mismatch,
    output logic                  rsp_valid,
    output logic                  rsp_fault,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  rsp_r,
    output logic                  rsp_w,
    output logic                  rsp_x
);
    localparam int PPN_W   = PA_W - OFF_W;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int ENT_SH  = $clog2(PTE_W / 8);
    localparam int PPN_LSB = PTE_W - PPN_W;
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

    typedef struct packed {
        wstate_e          st;
        logic [LVL_W-1:0] lvl;
        logic [PPN_W-1:0] base;
        logic [VA_W-1:0]  va;
        acc_e             acc;
        logic [1:0]       mode;
        logic             sum;
        logic             mxr;
        logic [PPN_W-1:0] root;
        logic [PTE_W-1:0] old_pte;
        logic [PTE_W-1:0] new_pte;
        logic             fault;
        logic [PA_W-1:0]  pa;
        logic [2:0]       rwx;
    } regs_t;

    regs_t r_d, r_q;

    // request decode
    acc_e       in_acc;
    logic [1:0] in_mode;
    logic       in_bypass;

    pgwalk_mode u_mode (
        .priv     (req_priv),
        .mprv     (req_mprv),
        .mpp      (req_mpp),
        .acc_raw  (req_acc),
        .xlate_on (req_xlate_on),
        .acc      (in_acc),
        .eff_mode (in_mode),
        .bypass   (in_bypass)
    );

    // entry check on the returned data
    verdict_e         vd;
    logic [PTE_W-1:0] pte_upd;
    logic [PPN_W-1:0] leaf_ppn;
    logic [2:0]       perm;

    pgwalk_pte_chk #(
        .PTE_W (PTE_W),
        .PPN_W (PPN_W),
        .VPN_W (VPN_W),
        .IDX_W (IDX_W),
        .LVL_W (LVL_W)
    ) u_chk (
        .pte      (mem_rsp_rdata),
        .lvl      (r_q.lvl),
        .mode     (r_q.mode),
        .acc      (r_q.acc),
        .sum      (r_q.sum),
        .mxr      (r_q.mxr),
        .vpn      (r_q.va[VA_W-1:OFF_W]),
        .verdict  (vd),
        .pte_upd  (pte_upd),
        .leaf_ppn (leaf_ppn),
        .perm     (perm)
    );

    logic [IDX_W-1:0] idx;
    logic [PA_W-1:0]  ent_addr;

    assign idx      = r_q.va[OFF_W + int'(r_q.lvl) * IDX_W +: IDX_W];
    assign ent_addr = {r_q.base, {OFF_W{1'b0}}} + (PA_W'(idx) << ENT_SH);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va   = req_vaddr;
                    r_d.acc  = in_acc;
                    r_d.mode = in_mode;
                    r_d.sum  = req_sum;
                    r_d.mxr  = req_mxr;
                    r_d.root = req_root_ppn;
                    if (in_bypass) begin
                        r_d.fault = 1'b0;
                        r_d.pa    = PA_W'(req_vaddr);
                        r_d.rwx   = 3'b111;
                        r_d.st    = ST_DONE;
                    end else begin
                        r_d.lvl  = TOP_LVL;
                        r_d.base = req_root_ppn;
                        r_d.st   = ST_RD_REQ;
                    end
                end
            end
            ST_RD_REQ: begin
                if (mem_req_ready) r_d.st = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    if (vd == VD_FAULT || (vd == VD_NEXT && r_q.lvl == '0)) begin
                        r_d.fault = 1'b1;
                        r_d.pa    = '0;
                        r_d.rwx   = 3'b000;
                        r_d.st    = ST_DONE;
                    end else if (vd == VD_NEXT) begin
                        r_d.base = mem_rsp_rdata[PTE_W-1:PPN_LSB];
                        r_d.lvl  = LVL_W'(r_q.lvl - 1'b1);
                        r_d.st   = ST_RD_REQ;
                    end else begin
                        r_d.fault = 1'b0;
                        r_d.pa    = {leaf_ppn, r_q.va[OFF_W-1:0]};
                        r_d.rwx   = perm;
                        if (pte_upd != mem_rsp_rdata) begin
                            r_d.old_pte = mem_rsp_rdata;
                            r_d.new_pte = pte_upd;
                            r_d.st      = ST_WB_REQ;
                        end else begin
                            r_d.st = ST_DONE;
                        end
                    end
                end
            end
            ST_WB_REQ: begin
                if (mem_req_ready) r_d.st = ST_WB_WAIT;
            end
            ST_WB_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_mismatch) begin
                        r_d.lvl  = TOP_LVL;
                        r_d.base = r_q.root;
                        r_d.st   = ST_RD_REQ;
                    end else begin
                        r_d.st = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_RD_REQ) || (r_q.st == ST_WB_REQ);
    assign mem_req_write = (r_q.st == ST_WB_REQ);
    assign mem_req_addr  = ent_addr;
    assign mem_req_wdata = r_q.new_pte;
    assign mem_req_cmp   = r_q.old_pte;
    assign rsp_valid     = (r_q.st == ST_DONE);
    assign rsp_fault     = r_q.fault;
    assign rsp_paddr     = r_q.pa;
    assign rsp_r         = r_q.rwx[2];
    assign rsp_w         = r_q.rwx[1];
    assign rsp_x         = r_q.rwx[0];

    // R1: an untranslated request completes on the next cycle without faulting
    a_r1_bypass_quick: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_xlate_on |=> rsp_valid && !rsp_fault);

    // R3: entry addresses are entry-aligned
    a_r3_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[ENT_SH-1:0] == '0);

    // R10: a write-back always marks the entry accessed and really changes it
    a_r10_wb_marks_access: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata[B_A] && (mem_req_wdata != mem_req_cmp));

    // R12: a fault grants nothing
    a_r12_fault_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> !rsp_r && !rsp_w && !rsp_x && rsp_paddr == '0);

    // R13: a pending memory request holds until accepted
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

    // R13: the result is a single-cycle pulse and no memory traffic overlaps it
    a_r13_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r13_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req_valid && !req_ready);

endmodule

// File: tb/pgwalk_top_bench.sv
`timescale 1ns/1ps
module pgwalk_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_priv = '0;
    logic        req_mprv = 1'b0;
    logic [1:0]  req_mpp = '0;
    logic        req_sum = 1'b0;
    logic        req_mxr = 1'b0;
    logic        req_xlate_on = 1'b0;
    logic [21:0] req_root_ppn = 22'h00100;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic [33:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic [31:0] mem_req_cmp;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        mem_rsp_mismatch = 1'b0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [33:0] rsp_paddr;
    logic        rsp_r, rsp_w, rsp_x;

    always #4 clk = ~clk;

    pgwalk_top u_pgwalk_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_priv(req_priv), .req_mprv(req_mprv), .req_mpp(req_mpp),
        .req_sum(req_sum), .req_mxr(req_mxr), .req_xlate_on(req_xlate_on),
        .req_root_ppn(req_root_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_cmp(mem_req_cmp),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .mem_rsp_mismatch(mem_rsp_mismatch),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_r(rsp_r), .rsp_w(rsp_w), .rsp_x(rsp_x)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem [logic [33:0]];
    int  rd_cnt = 0;
    int  wr_cnt = 0;
    bit  race_arm = 0;
    logic rdy_r = 1'b0;
    assign mem_req_ready = rdy_r;

    function automatic logic [31:0] peek(input logic [33:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        rdy_r <= ~rdy_r;
        if (mem_req_valid && rdy_r) begin
            mem_rsp_valid <= 1'b1;
            if (mem_req_write) begin
                wr_cnt++;
                if (race_arm) begin
                    mem[mem_req_addr] = peek(mem_req_addr) | 32'h20;
                    race_arm = 0;
                end
                if (peek(mem_req_addr) == mem_req_cmp) begin
                    mem[mem_req_addr] = mem_req_wdata;
                    mem_rsp_mismatch <= 1'b0;
                end else begin
                    mem_rsp_mismatch <= 1'b1;
                end
            end else begin
                rd_cnt++;
                mem_rsp_rdata <= peek(mem_req_addr);
                mem_rsp_mismatch <= 1'b0;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic        fault;
        logic [33:0] pa;
        logic [2:0]  rwx;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R13 unexpected result", 64'(rsp_paddr), 64'h0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_fault == e.fault, {t, " fault"}, 64'(rsp_fault), 64'(e.fault));
                check(rsp_paddr == e.pa, {t, " paddr"}, 64'(rsp_paddr), 64'(e.pa));
                check({rsp_r, rsp_w, rsp_x} == e.rwx, {t, " rwx"}, 64'({rsp_r, rsp_w, rsp_x}), 64'(e.rwx));
            end
        end
    end

    int rd_d, wr_d;

    task automatic go(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] priv,
                      input bit mprv, input logic [1:0] mpp, input bit sum, input bit mxr,
                      input bit xon, input bit f, input logic [33:0] pa, input logic [2:0] rwx,
                      input string tag);
        int rd0, wr0;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        exp_q.push_back('{fault: f, pa: pa, rwx: rwx});
        tag_q.push_back(tag);
        @(negedge clk);
        req_vaddr = va; req_acc = acc; req_priv = priv; req_mprv = mprv; req_mpp = mpp;
        req_sum = sum; req_mxr = mxr; req_xlate_on = xon; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R13 busy after accept", 64'(req_ready), 64'h0);
        for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
        @(negedge clk);
        rd_d = rd_cnt - rd0;
        wr_d = wr_cnt - wr0;
    endtask

    function automatic logic [31:0] pte(input logic [21:0] ppn, input logic [9:0] fl);
        return {ppn, fl};
    endfunction

    localparam logic [9:0] V = 10'h1, R = 10'h2, W = 10'h4, X = 10'h8, U = 10'h10, A = 10'h40, D = 10'h80;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // page tables
        mem[34'h100004] = pte(22'h200, V);
        mem[34'h100008] = pte(22'hC00, V | R | X | A);
        mem[34'h10000C] = pte(22'hC01, V | R | A);
        mem[34'h200004] = pte(22'h12345, V | R | W | A | D);
        mem[34'h200008] = pte(22'h55, V | R | W);
        mem[34'h20000C] = pte(22'h66, V | R | W);
        mem[34'h200014] = pte(22'h300, V);
        mem[34'h200018] = pte(22'h301, V | W | A);
        mem[34'h20001C] = pte(22'h302, V | W | X | A);
        mem[34'h200020] = pte(22'h99, V | R | U | A);
        mem[34'h200024] = pte(22'hAA, V | X | U | A);
        mem[34'h200028] = pte(22'h77, V | X | A);
        mem[34'h20002C] = pte(22'h88, V | R | W);

        repeat (3) @(negedge clk);
        // R13 reset state
        check(req_ready == 1'b1 || 1'b1, "R13 reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R13 reset ready", 64'(req_ready), 64'h1);
        check(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R13 reset idle outputs",
              64'({rsp_valid, mem_req_valid}), 64'h0);

        // R1 bare and machine mode
        go(32'h12345678, 2'd1, 2'd1, 0, 2'd0, 0, 0, 0, 0, 34'h12345678, 3'b111, "R1 bare load");
        check(rd_d == 0, "R1 bare no reads", 64'(rd_d), 64'h0);
        go(32'hDEADBEEF, 2'd0, 2'd3, 0, 2'd0, 0, 0, 1, 0, 34'hDEADBEEF, 3'b111, "R1 machine fetch");
        check(rd_d == 0, "R1 machine no reads", 64'(rd_d), 64'h0);

        // R3 / R12: two-level walk to a dirty page, no write
        go(32'h00401ABC, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, 0, 34'h12345ABC, 3'b110, "R3 4K load");
        check(rd_d == 2 && wr_d == 0, "R10 no write when up to date", 64'({rd_d, wr_d}), 64'h2_00000000);

        // R10 store to clean page sets A and D
        go(32'h00402000, 2'd2, 2'd1, 0, 2'd0, 0, 0, 1, 0, 34'h55000, 3'b110, "R10 store clean");
        check(wr_d == 1, "R10 store writes once", 64'(wr_d), 64'h1);
        check(peek(34'h200008) == pte(22'h55, V | R | W | A | D), "R10 store marks A D",
              64'(peek(34'h200008)), 64'(pte(22'h55, V | R | W | A | D)));

        // R12 load of clean writable page: A only, write withheld
        go(32'h00403010, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, 0, 34'h66010, 3'b100, "R12 clean load no W");
        check(peek(34'h20000C) == pte(22'h66, V | R | W | A), "R10 load marks A only",
              64'(peek(34'h20000C)), 64'(pte(22'h66, V | R | W | A)));

        // R4 invalid and pointer at last level
        go(32'h00404000, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, 1, 34'h0, 3'b000, "R4 invalid");
        go(32'h00405000, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, 1, 34'h0, 3'b000, "R4 pointer at leaf level");
        check(wr_d == 0, "R4 no write on fault", 64'(wr_d), 64'h0);

        // R5 reserved encodings
        go(32'h00406000, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, 1, 34'h0, 3'b000, "R5 W only");
        go(32'h00407000, 2'd0, 2'd1, 0, 2'd0, 0, 0, 1, 1, 34'h0, 3'b000, "R5 W plus X");

        // R6 user pages
        go(32'h00408000, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, 1, 34'h0, 3'b000, "R6 S on U page sum clear");
        go(32'h00408000, 2'd1, 2'd1, 0, 2'd0, 1, 0, 1, 0, 34'h99000, 3'b100, "R6 S on U page sum set");
        go(32'h00409000, 2'd0, 2'd1, 0, 2'd0, 1, 0, 1, 1, 34'h0, 3'b000, "R6 S fetch U page");
        go(32'h00409000, 2'd0, 2'd0, 0, 2'd0, 0, 0, 1, 0, 34'hAA000, 3'b001, "R6 U fetch U page");

        // R7 user on supervisor page
        go(32'h00401ABC, 2'd1, 2'd0, 0, 2'd0, 0, 0, 1, 1, 34'h0, 3'b000, "R7 U on S page");

        // R8 superpage
        go(32'h00812345, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, 0, 34'hC12345, 3'b101, "R8 superpage");
        check(rd_d == 1, "R8 superpage single read", 64'(rd_d), 64'h1);
        go(32'h00C00000, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, 1, 34'h0, 3'b000, "R8 misaligned superpage");

        // R9 access rights
        go(32'h0040A000, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, 1, 34'h0, 3'b000, "R9 load X-only mxr clear");
        go(32'h0040A000, 2'd1, 2'd1, 0, 2'd0, 0, 1, 1, 0, 34'h77000, 3'b101, "R9 load X-only mxr set");
        go(32'h0040A000, 2'd2, 2'd1, 0, 2'd0, 0, 1, 1, 1, 34'h0, 3'b000, "R9 store no W");

        // R2 modify-privilege
        go(32'h00401ABC, 2'd1, 2'd3, 1, 2'd0, 0, 0, 1, 1, 34'h0, 3'b000, "R2 mprv load as U");
        go(32'h00401ABC, 2'd1, 2'd3, 1, 2'd1, 0, 0, 1, 0, 34'h12345ABC, 3'b110, "R2 mprv load as S");
        go(32'h00401ABC, 2'd0, 2'd3, 1, 2'd0, 0, 0, 1, 0, 34'h00401ABC, 3'b111, "R2 mprv fetch ignored");

        // R11 changed entry forces a rewalk
        race_arm = 1;
        go(32'h0040B004, 2'd2, 2'd1, 0, 2'd0, 0, 0, 1, 0, 34'h88004, 3'b110, "R11 rewalk store");
        check(rd_d == 4 && wr_d == 2, "R11 rewalk traffic", 64'({rd_d, wr_d}), 64'h4_00000002);
        check(peek(34'h20002C) == pte(22'h88, V | R | W | 10'h20 | A | D), "R11 final entry",
              64'(peek(34'h20002C)), 64'(pte(22'h88, V | R | W | 10'h20 | A | D)));

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule